// File: doc/BRIEF.md
# I2C Address Alias Remapper

This block sits on the forward path of an I2C bridge, between the local host side and the link that carries transactions to a remote bus. For every address byte that the local side presents, it compares the upper seven bits with an alias programmed for the link port that the transaction is headed to. On a hit, it forwards the byte one cycle later with those seven bits replaced by the programmed real target address. On a miss, it raises a one-cycle NACK instead, and the local host's transaction is refused.

Each link port has its own alias and target pair. Software reaches the pairs through a small register window. A port-select bit in a control register decides which port's pair the alias and target registers show and modify. An entry with a zero alias or a zero target is disabled. Both fields reset to zero, so nothing is forwarded until software programs a pair.

Top module: `i2c_alias_remap`

## Requirements
- R1: After reset, every alias field, every target field and the port select are zero, every register offset reads 0x00, and `fwd_valid` and `nack` are low.
- R2: The register window uses `reg_addr` offsets 0 (control), 1 (target) and 2 (alias). The target and alias fields are written from `reg_wdata[7:1]` and read back in bits 7:1 with bit 0 reading 0. Writes to offset 3 are ignored, and offset 3 reads 0x00.
- R3: Control bit 0 is the port select. It reads back at offset 0. Reads and writes of the target and alias offsets reach only the selected port's pair and leave the other port's pair unchanged.
- R4: When `req_valid` is high and `req_byte[7:1]` equals the enabled alias of port `req_port`, the next cycle shows `fwd_valid` high with `fwd_byte[7:1]` equal to that port's target.
- R5: `fwd_byte[0]` (the read/write bit) equals `req_byte[0]` of the request that produced it.
- R6: An entry whose alias is zero or whose target is zero never matches, including for address byte 0x00 or 0x01.
- R7: A request that hits no enabled alias gives `nack` high for exactly the next cycle, with `fwd_valid` low.
- R8: The match uses the pair of `req_port`, not the pair picked by the port select, and `fwd_port` repeats `req_port`.
- R9: `fwd_valid` and `nack` are never high together. Either one is high only in the cycle right after a cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 target, 2 alias |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Address byte present from the local host |
| req_byte | input | 8 | Address byte: 7-bit address in bits 7:1, R/W in bit 0 |
| req_port | input | PW (1) | Link port the transaction targets |
| fwd_valid | output | 1 | Remapped byte valid toward the link |
| fwd_byte | output | 8 | Remapped address byte |
| fwd_port | output | PW (1) | Port of the forwarded byte |
| nack | output | 1 | No enabled alias hit; refuse the transaction |

## Verification
The bench builds the block with its default of two ports. This gives a one-bit port select, so every select value and both pairs are reachable, along with the case where the select and the request port disagree. Random address bytes are biased toward the programmed aliases so that hits, misses and read/write bit values all occur often. Directed steps zero each field in turn and send address 0x00 to exercise the disable rule.

// File: rtl/i2c_remap_pkg.sv
package i2c_remap_pkg;
    localparam int AW = 7;          // I2C address width
    localparam int DW = AW + 1;     // register and address byte width

    typedef logic [AW-1:0] addr7_t;

    typedef struct packed {
        addr7_t src_id;   // alias seen on the local bus
        addr7_t dst_id;   // real address on the remote bus
    } pair_t;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DST  = 2'd1,
        REG_SRC  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/remap_bank.sv
module remap_bank
    import i2c_remap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_dst,
    input  logic   wr_src,
    input  addr7_t wdata,
    output pair_t  pair
);
    pair_t pair_d, pair_q;

    always_comb begin
        pair_d = pair_q;
        if (wr_dst) pair_d.dst_id = wdata;
        if (wr_src) pair_d.src_id = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pair_q <= '0;
        else        pair_q <= pair_d;
    end

    assign pair = pair_q;
endmodule

// File: rtl/remap_match.sv
module remap_match
    import i2c_remap_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  pair_t         pairs [NUM_PORTS],
    input  logic [PW-1:0] port,
    input  addr7_t        addr,
    output logic          hit,
    output addr7_t        dst
);
    pair_t sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (port == PW'(i)) sel = pairs[i];
        end
        // an all-zero alias or target disables the entry
        hit = (sel.src_id != '0) && (sel.dst_id != '0) && (sel.src_id == addr);
        dst = sel.dst_id;
    end
endmodule

// File: rtl/i2c_alias_remap.sv
module i2c_alias_remap
    import i2c_remap_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          req_valid,
    input  logic [DW-1:0] req_byte,
    input  logic [PW-1:0] req_port,
    output logic          fwd_valid,
    output logic [DW-1:0] fwd_byte,
    output logic [PW-1:0] fwd_port,
    output logic          nack
);
    typedef struct packed {
        logic [PW-1:0] psel;
        logic          fwd_valid;
        logic          nack;
        logic [DW-1:0] fwd_byte;
        logic [PW-1:0] fwd_port;
    } state_t;

    state_t   st_d, st_q;
    pair_t    pairs [NUM_PORTS];
    reg_sel_e rsel;
    logic     hit;
    addr7_t   hit_dst;
    pair_t    cur;

    assign rsel = reg_sel_e'(reg_addr);

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_bank
        remap_bank u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_dst (reg_wr && rsel == REG_DST && st_q.psel == PW'(g)),
            .wr_src (reg_wr && rsel == REG_SRC && st_q.psel == PW'(g)),
            .wdata  (reg_wdata[DW-1:1]),
            .pair   (pairs[g])
        );
    end

    remap_match #(.NUM_PORTS(NUM_PORTS)) u_match (
        .pairs (pairs),
        .port  (req_port),
        .addr  (req_byte[DW-1:1]),
        .hit   (hit),
        .dst   (hit_dst)
    );

    // pair shown through the register window
    always_comb begin
        cur = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (st_q.psel == PW'(i)) cur = pairs[i];
        end
    end

    always_comb begin
        case (rsel)
            REG_CTRL: reg_rdata = DW'(st_q.psel);
            REG_DST:  reg_rdata = {cur.dst_id, 1'b0};
            REG_SRC:  reg_rdata = {cur.src_id, 1'b0};
            default:  reg_rdata = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && rsel == REG_CTRL && 32'(reg_wdata[PW-1:0]) < NUM_PORTS)
            st_d.psel = reg_wdata[PW-1:0];
        st_d.fwd_valid = req_valid && hit;
        st_d.nack      = req_valid && !hit;
        if (req_valid) begin
            st_d.fwd_byte = {hit ? hit_dst : req_byte[DW-1:1], req_byte[0]};
            st_d.fwd_port = req_port;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fwd_valid = st_q.fwd_valid;
    assign fwd_byte  = st_q.fwd_byte;
    assign fwd_port  = st_q.fwd_port;
    assign nack      = st_q.nack;
endmodule

// File: rtl/i2c_alias_remap_chk.sv
module i2c_alias_remap_chk #(
    parameter int PW = 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic [7:0]   req_byte,
    input logic [PW-1:0] req_port,
    input logic         fwd_valid,
    input logic [7:0]   fwd_byte,
    input logic [PW-1:0] fwd_port,
    input logic         nack
);
    // R9
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fwd_valid, nack}));

    // R9
    out_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid || nack) |-> $past(req_valid));

    // R7
    req_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (fwd_valid || nack));

    // R5
    rw_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> fwd_byte[0] == $past(req_byte[0]));

    // R6
    nonzero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> fwd_byte[7:1] != 7'd0);

    // R6
    zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_byte[7:1] == 7'd0) |=> nack);

    // R8
    port_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> fwd_port == $past(req_port));
endmodule

bind i2c_alias_remap i2c_alias_remap_chk #(.PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_byte  (req_byte),
    .req_port  (req_port),
    .fwd_valid (fwd_valid),
    .fwd_byte  (fwd_byte),
    .fwd_port  (fwd_port),
    .nack      (nack)
);

// File: tb/sim_i2c_alias_remap.sv
`timescale 1ns/1ps
module sim_i2c_alias_remap;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       req_valid = 1'b0;
    logic [7:0] req_byte = 8'd0;
    logic [0:0] req_port = 1'b0;
    logic       fwd_valid;
    logic [7:0] fwd_byte;
    logic [0:0] fwd_port;
    logic       nack;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [6:0] m_src [2];
    logic [6:0] m_dst [2];
    logic       m_psel;

    always #4 clk = ~clk;   // 125 MHz

    i2c_alias_remap u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_byte(req_byte), .req_port(req_port), .fwd_valid(fwd_valid),
        .fwd_byte(fwd_byte), .fwd_port(fwd_port), .nack(nack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return {7'd0, m_psel};
            2'd1: return {m_dst[m_psel], 1'b0};
            2'd2: return {m_src[m_psel], 1'b0};
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic exp_hit(input logic [7:0] b, input logic p);
        return m_src[p] != 0 && m_dst[p] != 0 && m_src[p] == b[7:1];
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            2'd0: m_psel = d[0];
            2'd1: m_dst[m_psel] = d[7:1];
            2'd2: m_src[m_psel] = d[7:1];
            default: ;
        endcase
    endtask

    task automatic reg_check(input logic [1:0] a, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp_read(a));
    endtask

    task automatic send(input logic [7:0] b, input logic p, input string tag);
        logic h;
        h = exp_hit(b, p);
        @(negedge clk);
        req_valid = 1'b1; req_byte = b; req_port = p;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " fwd_valid R4"}, fwd_valid, h);
        chk({tag, " nack R7"}, nack, !h);
        if (h) begin
            chk({tag, " addr R4"}, fwd_byte[7:1], m_dst[p]);
            chk({tag, " rw R5"}, fwd_byte[0], b[0]);
            chk({tag, " port R8"}, fwd_port, p);
        end
        @(negedge clk);
        chk({tag, " idle R9"}, {fwd_valid, nack}, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_src[0] = 0; m_src[1] = 0; m_dst[0] = 0; m_dst[1] = 0; m_psel = 0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 outputs", {fwd_valid, nack}, 2'b00);
        for (int a = 0; a < 4; a++) reg_check(2'(a), "R1 reset read");
        send(8'h00, 1'b0, "R1 r6_ zero addr after reset");
        send(8'h42, 1'b1, "R1 unprogrammed");

        // R2 field write/read with bit0 set
        reg_write(2'd2, 8'h43);
        reg_write(2'd1, 8'hA1);
        reg_check(2'd2, "R2 alias read");
        reg_check(2'd1, "R2 target read");
        reg_write(2'd3, 8'hFF);
        reg_check(2'd3, "R2 unused offset");
        reg_check(2'd0, "R2 ctrl untouched");

        // R4 / R5 hit with both rw values
        send(8'h42, 1'b0, "R4 write hit");
        send(8'h43, 1'b0, "R5 read hit");
        send(8'h44, 1'b0, "R7 miss");
        // R8 other port not programmed
        send(8'h42, 1'b1, "R8 port1 miss");

        // R3 switch bank
        reg_write(2'd0, 8'h01);
        reg_check(2'd0, "R3 psel read");
        reg_check(2'd1, "R3 port1 target zero");
        reg_write(2'd2, 8'h42);
        reg_write(2'd1, 8'h20);
        reg_write(2'd0, 8'h00);
        reg_check(2'd1, "R3 port0 target kept");
        reg_check(2'd2, "R3 port0 alias kept");
        // R8 select is port0 but request goes to port1
        send(8'h42, 1'b1, "R8 port1 hit");
        send(8'h43, 1'b0, "R8 port0 hit");

        // R6 zero target disables
        reg_write(2'd1, 8'h00);
        send(8'h42, 1'b0, "R6 zero target");
        reg_write(2'd1, 8'h22);
        reg_write(2'd2, 8'h00);
        send(8'h00, 1'b0, "R6 zero alias addr0");
        send(8'h01, 1'b0, "R6 zero alias addr0 rd");
        send(8'h42, 1'b0, "R6 zero alias old addr");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned r;
            r = $urandom % 10;
            if (r < 2) begin
                logic [6:0] v;
                v = ($urandom % 4 == 0) ? 7'd0 : 7'($urandom);
                reg_write(2'($urandom % 4), {v, 1'($urandom)});
            end else if (r < 3) begin
                reg_check(2'($urandom % 4), "R2 r3_ random read");
            end else begin
                logic p;
                logic [6:0] a;
                p = 1'($urandom);
                a = ($urandom % 2 == 0) ? m_src[p] : 7'($urandom);
                send({a, 1'($urandom)}, p, "R4 random");
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule